// File: doc/BRIEF.md
# Trap-Lock Gated Status Register Access

This block holds the status words that a supervisor and a guest supervisor see, together with two configuration enables that decide whether a trap-lock bit in those words is visible and writable. One status word belongs to the machine. The supervisor sees a masked view of that same storage. A second, separate status word belongs to the guest. A machine-level enable gates the lock bit in the supervisor view. A guest-level enable gates the lock bit in the guest word. The guest-level enable can itself only be set, and only reads back, while the machine-level enable is on.

A single access port selects one of five registers. A read returns the masked value in the same cycle. A write commits on the next rising clock edge. When a write through either supervisor-level view leaves the lock bit at 1, the interrupt-enable bit of that word is cleared in the stored value. The parameter `EXT_EN` removes the whole trap-lock feature when it is 0.

Top module: `dt_status_access`

## Requirements
- R1: While `rst_n` is low, every register reads 0, and reset takes effect without a clock edge.
- R2: A write to select 0 (machine status) updates bit 1 (interrupt enable), bits 7:4 (plain writable bits) and, when `EXT_EN`=1, bit 24 (trap lock). Every other bit reads 0. Selects 5 to 7 read 0.
- R3: A write to select 1 (supervisor view) updates the interrupt-enable bit and the plain bits of the machine status word. It changes the lock bit only while the machine enable is 1. The result is visible through select 0.
- R4: A read of select 1 returns the machine status word with the lock bit shown as 0 whenever the machine enable is 0.
- R5: Select 2 (guest status) is separate storage. Its lock bit is writable and visible only while the effective guest enable (select 4 read value) is 1.
- R6: After a write through select 1 or 2, if the merged lock bit is 1, the stored interrupt-enable bit is 0. This applies even when the lock bit was already 1 and the write tried to set interrupt enable.
- R7: Select 4 (guest config, enable at bit 59) reads 0 and ignores writes while the machine enable is 0. A value stored earlier reappears once the machine enable returns to 1.
- R8: Select 3 (machine config) stores bit 59 as the machine enable when `EXT_EN`=1. With `EXT_EN`=0, neither enable nor lock can be written, and both always read 0.
- R9: A read reflects the selected register combinationally. A write with `acc_we` high changes stored state only at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_sel | input | 3 | Register select: 0 machine status, 1 supervisor view, 2 guest status, 3 machine config, 4 guest config |
| acc_we | input | 1 | Write strobe |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Masked read data for the selected register |

## Verification
On every cycle, the embedded properties check three things. Writes through a gated view leave the lock bit alone while its enable is off. A view write never leaves both the lock and interrupt-enable bits set. The hidden lock bit and the guest enable read 0 while the machine enable is off. Only the bench's scenarios can show the rest. That includes a lock bit hidden under a cleared enable and showing again once the enable returns, a guest enable restored after the machine enable is toggled, and the interlock firing on a lock bit that was already set. The same holds for the edge timing of writes and for the feature being removed entirely.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [2:0] {
    SEL_MSTAT = 3'd0,
    SEL_SVIEW = 3'd1,
    SEL_GSTAT = 3'd2,
    SEL_MCFG  = 3'd3,
    SEL_GCFG  = 3'd4
  } acc_sel_e;
endpackage

// File: rtl/dt_cfg_regs.sv
module dt_cfg_regs #(
  parameter bit EXT_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_m,
  input  logic wr_g,
  input  logic wbit,
  output logic m_en,
  output logic g_eff
);
  logic m_q, m_nx, g_q, g_nx;

  always_comb begin
    m_nx = m_q;
    g_nx = g_q;
    if (EXT_EN && wr_m) m_nx = wbit;
    if (EXT_EN && wr_g && m_q) g_nx = wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= 1'b0;
      g_q <= 1'b0;
    end else begin
      if (wr_m) m_q <= m_nx;
      if (wr_g) g_q <= g_nx;
    end
  end

  assign m_en  = m_q;
  assign g_eff = g_q & m_q;

  p_gcfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_g && !m_q) |=> $stable(g_q));

  generate
    if (!EXT_EN) begin : g_noext
      p_noext_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_m |=> !m_q);
    end
  endgenerate
endmodule

// File: rtl/dt_stat_word.sv
module dt_stat_word #(
  parameter int       W         = 64,
  parameter int       IE_BIT    = 1,
  parameter int       LOCK_BIT  = 24,
  parameter logic [W-1:0] PASS_MASK = 64'h0000_0000_0000_00F0,
  parameter bit       EXT_EN    = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_full,
  input  logic         wr_view,
  input  logic         gate_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] full_rdata,
  output logic [W-1:0] view_rdata
);
  localparam logic [W-1:0] IE_M   = W'(1) << IE_BIT;
  localparam logic [W-1:0] LOCK_M = W'(1) << LOCK_BIT;
  localparam logic [W-1:0] BASE_M = IE_M | PASS_MASK;
  localparam logic [W-1:0] FULL_M = BASE_M | (EXT_EN ? LOCK_M : '0);

  logic [W-1:0] q, nx, view_m, merged;

  always_comb begin
    view_m = BASE_M | ((EXT_EN && gate_en) ? LOCK_M : '0);
    merged = (q & ~view_m) | (wdata & view_m);
    if (merged[LOCK_BIT]) merged[IE_BIT] = 1'b0;
    nx = q;
    if (wr_full)      nx = (q & ~FULL_M) | (wdata & FULL_M);
    else if (wr_view) nx = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= '0;
    else if (wr_full || wr_view) q <= nx;
  end

  assign full_rdata = q & FULL_M;
  assign view_rdata = q & view_m;

  p_view_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_view && !wr_full && !gate_en) |=> $stable(q[LOCK_BIT]));

  p_interlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_view && !wr_full) |=> !(q[LOCK_BIT] && q[IE_BIT]));
endmodule

// File: rtl/dt_status_access.sv
module dt_status_access #(
  parameter int           W         = 64,
  parameter int           IE_BIT    = 1,
  parameter int           LOCK_BIT  = 24,
  parameter int           EN_BIT    = 59,
  parameter logic [W-1:0] PASS_MASK = 64'h0000_0000_0000_00F0,
  parameter bit           EXT_EN    = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   acc_sel,
  input  logic         acc_we,
  input  logic [W-1:0] acc_wdata,
  output logic [W-1:0] acc_rdata
);
  import dt_pkg::*;

  acc_sel_e     sel;
  logic         m_en, g_eff;
  logic [W-1:0] m_full, m_view, g_full, g_view;
  logic         wr_mstat, wr_sview, wr_gstat, wr_mcfg, wr_gcfg;

  assign sel      = acc_sel_e'(acc_sel);
  assign wr_mstat = acc_we && (sel == SEL_MSTAT);
  assign wr_sview = acc_we && (sel == SEL_SVIEW);
  assign wr_gstat = acc_we && (sel == SEL_GSTAT);
  assign wr_mcfg  = acc_we && (sel == SEL_MCFG);
  assign wr_gcfg  = acc_we && (sel == SEL_GCFG);

  dt_cfg_regs #(.EXT_EN(EXT_EN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_m(wr_mcfg), .wr_g(wr_gcfg),
    .wbit(acc_wdata[EN_BIT]), .m_en(m_en), .g_eff(g_eff)
  );

  dt_stat_word #(.W(W), .IE_BIT(IE_BIT), .LOCK_BIT(LOCK_BIT),
                 .PASS_MASK(PASS_MASK), .EXT_EN(EXT_EN)) u_mword (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_mstat), .wr_view(wr_sview),
    .gate_en(m_en), .wdata(acc_wdata), .full_rdata(m_full), .view_rdata(m_view)
  );

  dt_stat_word #(.W(W), .IE_BIT(IE_BIT), .LOCK_BIT(LOCK_BIT),
                 .PASS_MASK(PASS_MASK), .EXT_EN(EXT_EN)) u_gword (
    .clk(clk), .rst_n(rst_n), .wr_full(1'b0), .wr_view(wr_gstat),
    .gate_en(g_eff), .wdata(acc_wdata), .full_rdata(g_full), .view_rdata(g_view)
  );

  always_comb begin
    case (sel)
      SEL_MSTAT: acc_rdata = m_full;
      SEL_SVIEW: acc_rdata = m_view;
      SEL_GSTAT: acc_rdata = g_view;
      SEL_MCFG:  acc_rdata = W'(m_en) << EN_BIT;
      SEL_GCFG:  acc_rdata = W'(g_eff) << EN_BIT;
      default:   acc_rdata = '0;
    endcase
  end

  p_sview_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_SVIEW && !m_en) |-> !acc_rdata[LOCK_BIT]);

  p_gcfg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_GCFG && !m_en) |-> (acc_rdata == '0));

  p_gstat_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_GSTAT && !g_eff) |-> !acc_rdata[LOCK_BIT]);

  p_unused_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel > 3'd4) |-> (acc_rdata == '0));
endmodule

// File: tb/dt_status_access_test.sv
module dt_status_access_test;
  localparam int PERIOD = 10;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] EN   = 64'h0800_0000_0000_0000;
  localparam logic [63:0] LK   = 64'h0000_0000_0100_0000;
  localparam int NV = 23;
  // {req, sel, we, wdata, expected read of same select after the step}
  localparam logic [135:0] VEC [NV] = '{
    {4'd1, 3'd0, 1'b0, 64'h0,          64'h0},          // R1
    {4'd1, 3'd3, 1'b0, 64'h0,          64'h0},          // R1
    {4'd2, 3'd0, 1'b1, ONES,           64'h10000F2},    // R2
    {4'd4, 3'd1, 1'b0, 64'h0,          64'hF2},         // R4 lock hidden
    {4'd3, 3'd1, 1'b1, 64'h0,          64'h0},          // R3
    {4'd3, 3'd0, 1'b0, 64'h0,          LK},             // R3 lock kept
    {4'd6, 3'd1, 1'b1, 64'hF2,         64'hF0},         // R6 old lock forces IE off
    {4'd6, 3'd0, 1'b0, 64'h0,          64'h10000F0},    // R6
    {4'd7, 3'd4, 1'b1, EN,             64'h0},          // R7 blocked
    {4'd8, 3'd3, 1'b1, EN,             EN},             // R8
    {4'd7, 3'd4, 1'b0, 64'h0,          64'h0},          // R7
    {4'd4, 3'd1, 1'b0, 64'h0,          64'h10000F0},    // R4 now visible
    {4'd3, 3'd1, 1'b1, 64'h2,          64'h2},          // R3 lock cleared
    {4'd6, 3'd1, 1'b1, 64'h1000002,    LK},             // R6
    {4'd5, 3'd2, 1'b1, ONES,           64'hF2},         // R5 gated
    {4'd7, 3'd4, 1'b1, EN,             EN},             // R7
    {4'd5, 3'd2, 1'b1, 64'h10000F2,    64'h10000F0},    // R5 R6
    {4'd8, 3'd3, 1'b1, 64'h0,          64'h0},          // R8
    {4'd7, 3'd4, 1'b0, 64'h0,          64'h0},          // R7
    {4'd5, 3'd2, 1'b0, 64'h0,          64'hF0},         // R5
    {4'd8, 3'd3, 1'b1, EN,             EN},             // R8
    {4'd7, 3'd4, 1'b0, 64'h0,          EN},             // R7 restored
    {4'd2, 3'd5, 1'b0, 64'h0,          64'h0}           // R2 unused select
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  acc_sel = 3'd0;
  logic        acc_we = 1'b0;
  logic [63:0] acc_wdata = 64'h0;
  logic [63:0] acc_rdata, nx_rdata;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dt_status_access uut (.clk(clk), .rst_n(rst_n), .acc_sel(acc_sel),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata));

  dt_status_access #(.EXT_EN(1'b0)) uut_nx (.clk(clk), .rst_n(rst_n),
    .acc_sel(acc_sel), .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_rdata(nx_rdata));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_sel   = VEC[i][131:129];
      acc_we    = VEC[i][128];
      acc_wdata = VEC[i][127:64];
      if (acc_we) begin
        @(negedge clk);
        acc_we = 1'b0;
      end
      #1 chk($sformatf("R%0d vec %0d", VEC[i][135:132], i), acc_rdata, VEC[i][63:0]);
    end

    // R9: write visible only after the edge; read follows select at once
    @(negedge clk);
    acc_sel = 3'd0; acc_wdata = 64'h0; acc_we = 1'b1;
    #1 chk("R9 before edge", acc_rdata, LK);
    @(posedge clk); #1;
    chk("R9 after edge", acc_rdata, 64'h0);
    @(negedge clk);
    acc_we = 1'b0;
    acc_sel = 3'd4;
    #1 chk("R9 select change", acc_rdata, EN);

    // R1: asynchronous reset clears everything
    @(negedge clk); #2;
    rst_n = 1'b0;
    #1;
    for (int s = 0; s < 5; s++) begin
      acc_sel = 3'(s);
      #1 chk("R1 reset", acc_rdata, 64'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R8: feature removed
    @(negedge clk);
    acc_sel = 3'd0; acc_wdata = ONES; acc_we = 1'b1;
    @(negedge clk);
    acc_we = 1'b0;
    #1 chk("R8 no lock", nx_rdata, 64'hF2);
    acc_sel = 3'd3; acc_we = 1'b1;
    @(negedge clk);
    acc_we = 1'b0;
    #1 chk("R8 no enable", nx_rdata, 64'h0);
    acc_sel = 3'd1;
    #1 chk("R8 view", nx_rdata, 64'hF2);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule